// File: doc/BRIEF.md
# Machine trap vector unit

This block holds the machine-level trap vector register and turns a taken trap into a redirect address. Software reaches the register through a simple CSR write strobe and a continuous read value. The register packs an aligned base address in its upper XLEN-2 bits and a two-bit mode selector in bits 1:0. A mode value of 0 sends every trap to the base. A mode value of 1 sends synchronous exceptions to the base and sends interrupts to base plus four times their cause code.

When the core takes a trap, it raises a one-cycle request together with an interrupt flag and a cause code. On the next clock cycle the unit presents the target program counter, the encoded cause word and a valid strobe. The cause word carries the interrupt flag in its top bit and the code in its low bits. The unit does not detect faults or rank competing interrupts. It does not save the faulting PC or change privilege. XLEN is 32 or 64.

Top module: `mtrap_vec_unit`

## Requirements
- R1: After reset the read value equals RESET_VEC with bits 1:0 forced to 0, which is direct mode, and the valid strobe is 0.
- R2: A CSR write loads wdata[XLEN-1:2] into the base field and, when wdata[1:0] is 0 (direct) or 1 (vectored), loads the mode field. The new value is visible on the read port after the write edge.
- R3: A CSR write whose wdata[1:0] is 2 or 3 keeps the previous mode and still loads the base field.
- R4: In direct mode (mode 0), every trap, interrupt or exception, targets the base address {base field, 2'b00}.
- R5: In vectored mode (mode 1), a synchronous exception (interrupt flag 0) targets the base address.
- R6: In vectored mode, an interrupt (interrupt flag 1) targets base + 4 × cause code, wrapping modulo 2^XLEN. For example, code 7 targets base + 0x1C.
- R7: The cause word has bit XLEN-1 equal to the interrupt flag, bits CAUSE_W-1:0 equal to the code, and all other bits 0.
- R8: Valid rises on the clock cycle after a sampled request and lasts one cycle per request. The target and cause outputs hold their last values while no request arrives.
- R9: When a CSR write and a trap request are sampled on the same edge, the trap uses the register value from before the write.
- R10: Bits 1:0 of the target PC are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csr_we_i | input | 1 | Write strobe for the vector register |
| csr_wdata_i | input | XLEN | Write data: base in [XLEN-1:2], mode in [1:0] |
| csr_rdata_o | output | XLEN | Current vector register value |
| trap_req_i | input | 1 | A trap is taken this cycle |
| trap_irq_i | input | 1 | 1 for an interrupt, 0 for a synchronous exception |
| trap_code_i | input | CAUSE_W | Cause code |
| tgt_valid_o | output | 1 | Target and cause are fresh this cycle |
| tgt_pc_o | output | XLEN | Redirect program counter |
| tgt_cause_o | output | XLEN | Encoded cause word |

## Verification
The bench runs traps in both modes with both flag values. A unit that offset exceptions in vectored mode, or offset interrupts in direct mode, would show a target off by four times the code. It writes mode values 2 and 3 after a vectored setting. A unit without write-any-read-legal filtering would then read back an illegal mode, or drop the base update. It places the base near the top of the address space so that a vectored interrupt target wraps, and it collides a write with a trap on one edge. A unit that forwarded the new value would redirect to the wrong base. It also checks that valid lasts exactly one cycle and that the outputs hold between traps.

// File: rtl/mtv_pkg.sv
package mtv_pkg;
  typedef enum logic [1:0] {
    MODE_DIRECT   = 2'd0,
    MODE_VECTORED = 2'd1
  } tvec_mode_e;

  function automatic logic mode_is_legal(input logic [1:0] m);
    return (m == MODE_DIRECT) || (m == MODE_VECTORED);
  endfunction
endpackage

// File: rtl/mtv_rst_sync.sv
module mtv_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/mtv_csr.sv
module mtv_csr
  import mtv_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter logic [XLEN-1:0] RESET_VEC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-3:0] base_o,
  output tvec_mode_e      mode_o,
  output logic [XLEN-1:0] rdata_o
);
  logic [XLEN-3:0] base_q, base_d;
  tvec_mode_e      mode_q, mode_d;

  always_comb begin
    base_d = base_q;
    mode_d = mode_q;
    if (we_i) begin
      base_d = wdata_i[XLEN-1:2];
      if (mode_is_legal(wdata_i[1:0])) mode_d = tvec_mode_e'(wdata_i[1:0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= RESET_VEC[XLEN-1:2];
      mode_q <= MODE_DIRECT;
    end else if (we_i) begin
      base_q <= base_d;
      mode_q <= mode_d;
    end
  end

  assign base_o  = base_q;
  assign mode_o  = mode_q;
  assign rdata_o = {base_q, mode_q};

  AST_WARL_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i[1]) |=> (mode_q == $past(mode_q))); // R3
  AST_BASE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (base_q == $past(wdata_i[XLEN-1:2]))); // R2
  AST_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q[1] == 1'b0); // R3
endmodule

// File: rtl/mtv_target.sv
module mtv_target
  import mtv_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 6
) (
  input  logic [XLEN-3:0]    base_i,
  input  tvec_mode_e         mode_i,
  input  logic               irq_i,
  input  logic [CAUSE_W-1:0] code_i,
  output logic [XLEN-1:0]    pc_o,
  output logic [XLEN-1:0]    cause_o
);
  localparam int unsigned OFS_PAD   = XLEN - CAUSE_W - 2;
  localparam int unsigned CAUSE_PAD = XLEN - CAUSE_W - 1;

  logic [XLEN-1:0] base_addr;
  logic [XLEN-1:0] offset;
  logic            use_offset;

  always_comb begin
    base_addr  = {base_i, 2'b00};
    use_offset = irq_i && (mode_i == MODE_VECTORED);
    offset     = use_offset ? {{OFS_PAD{1'b0}}, code_i, 2'b00} : '0;
    pc_o       = base_addr + offset;
    cause_o    = {irq_i, {CAUSE_PAD{1'b0}}, code_i};
  end
endmodule

// File: rtl/mtv_out_reg.sv
module mtv_out_reg #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] cause_i,
  output logic            valid_o,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] cause_o
);
  logic            valid_q;
  logic [XLEN-1:0] pc_q, cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      cause_q <= '0;
    end else if (en_i) begin
      pc_q    <= pc_i;
      cause_q <= cause_i;
    end
  end

  assign valid_o = valid_q;
  assign pc_o    = pc_q;
  assign cause_o = cause_q;

  AST_VALID_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> valid_q); // R8
  AST_VALID_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !valid_q); // R8
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(pc_q) && $stable(cause_q))); // R8
endmodule

// File: rtl/mtrap_vec_unit.sv
module mtrap_vec_unit
  import mtv_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 6,
  parameter logic [XLEN-1:0] RESET_VEC = 'h8000_0100
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               csr_we_i,
  input  logic [XLEN-1:0]    csr_wdata_i,
  output logic [XLEN-1:0]    csr_rdata_o,
  input  logic               trap_req_i,
  input  logic               trap_irq_i,
  input  logic [CAUSE_W-1:0] trap_code_i,
  output logic               tgt_valid_o,
  output logic [XLEN-1:0]    tgt_pc_o,
  output logic [XLEN-1:0]    tgt_cause_o
);
  logic            rst_n;
  logic [XLEN-3:0] base;
  tvec_mode_e      mode;
  logic [XLEN-1:0] next_pc, next_cause;

  mtv_rst_sync u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(rst_n)
  );

  mtv_csr #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) u_csr (
    .clk_i(clk_i), .rst_ni(rst_n), .we_i(csr_we_i), .wdata_i(csr_wdata_i),
    .base_o(base), .mode_o(mode), .rdata_o(csr_rdata_o)
  );

  mtv_target #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_tgt (
    .base_i(base), .mode_i(mode), .irq_i(trap_irq_i), .code_i(trap_code_i),
    .pc_o(next_pc), .cause_o(next_cause)
  );

  mtv_out_reg #(.XLEN(XLEN)) u_out (
    .clk_i(clk_i), .rst_ni(rst_n), .en_i(trap_req_i),
    .pc_i(next_pc), .cause_i(next_cause),
    .valid_o(tgt_valid_o), .pc_o(tgt_pc_o), .cause_o(tgt_cause_o)
  );

  AST_EXC_TO_BASE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (trap_req_i && !trap_irq_i) |=> (tgt_pc_o[XLEN-1:2] == $past(csr_rdata_o[XLEN-1:2]))); // R5
  AST_DIRECT_TO_BASE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (trap_req_i && (csr_rdata_o[1:0] == 2'd0)) |=> (tgt_pc_o[XLEN-1:2] == $past(csr_rdata_o[XLEN-1:2]))); // R4
  AST_IRQ_STRIDE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (trap_req_i && trap_irq_i && (csr_rdata_o[1:0] == 2'd1)) |=>
      ((tgt_pc_o - {$past(csr_rdata_o[XLEN-1:2]), 2'b00}) >> 2 == XLEN'($past(trap_code_i)))); // R6
  AST_CAUSE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_n)
    trap_req_i |=> (tgt_cause_o[XLEN-1] == $past(trap_irq_i))); // R7
  AST_PC_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_n)
    tgt_valid_o |-> (tgt_pc_o[1:0] == 2'b00)); // R10
endmodule

// File: tb/sim_mtrap_vec_unit.sv
module sim_mtrap_vec_unit;
  localparam int XLEN = 32;
  localparam int CW   = 6;
  localparam logic [31:0] RV = 32'h8000_0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic req = 1'b0, irq = 1'b0;
  logic [CW-1:0] code = '0;
  logic valid;
  logic [31:0] pc, cause;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mtrap_vec_unit #(.XLEN(XLEN), .CAUSE_W(CW), .RESET_VEC(RV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .csr_we_i(we), .csr_wdata_i(wdata),
    .csr_rdata_o(rdata), .trap_req_i(req), .trap_irq_i(irq),
    .trap_code_i(code), .tgt_valid_o(valid), .tgt_pc_o(pc), .tgt_cause_o(cause)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [31:0] d);
    @(negedge clk); we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic take_trap(input logic i, input logic [CW-1:0] c);
    @(negedge clk); req = 1'b1; irq = i; code = c;
    @(negedge clk); req = 1'b0;
  endtask

  function automatic logic [31:0] enc(input logic i, input logic [CW-1:0] c);
    return {i, 25'd0, c};
  endfunction

  task automatic t_reset;
    chk("R1 reset rdata", rdata, 32'h8000_0100);
    chk("R1 reset valid", {31'd0, valid}, 32'd0);
  endtask

  task automatic t_direct;
    csr_wr(32'h0000_2000);
    chk("R2 write direct", rdata, 32'h0000_2000);
    take_trap(1'b1, 6'd7);
    chk("R4 direct irq pc", pc, 32'h0000_2000);
    chk("R8 valid after req", {31'd0, valid}, 32'd1);
    chk("R7 irq cause", cause, enc(1'b1, 6'd7));
    take_trap(1'b0, 6'd2);
    chk("R4 direct exc pc", pc, 32'h0000_2000);
    chk("R7 exc cause", cause, enc(1'b0, 6'd2));
  endtask

  task automatic t_vectored;
    csr_wr(32'h0000_4001);
    chk("R2 write vectored", rdata, 32'h0000_4001);
    take_trap(1'b0, 6'd11);
    chk("R5 vec exc pc", pc, 32'h0000_4000);
    chk("R7 ecall cause", cause, enc(1'b0, 6'd11));
    take_trap(1'b1, 6'd7);
    chk("R6 vec timer pc", pc, 32'h0000_401C);
    chk("R10 pc aligned", {30'd0, pc[1:0]}, 32'd0);
    take_trap(1'b1, 6'd11);
    chk("R6 vec ext pc", pc, 32'h0000_402C);
    chk("R7 ext cause", cause, enc(1'b1, 6'd11));
    @(negedge clk);
    chk("R8 valid one cycle", {31'd0, valid}, 32'd0);
    chk("R8 pc held", pc, 32'h0000_402C);
    chk("R8 cause held", cause, enc(1'b1, 6'd11));
  endtask

  task automatic t_warl;
    csr_wr(32'h0000_6002);
    chk("R3 mode 2 ignored", rdata, 32'h0000_6001);
    csr_wr(32'h0000_7003);
    chk("R3 mode 3 ignored", rdata, 32'h0000_7001);
    take_trap(1'b1, 6'd3);
    chk("R3 still vectored", pc, 32'h0000_700C);
    csr_wr(32'h0000_5000);
    csr_wr(32'h0000_8003);
    chk("R3 direct kept", rdata, 32'h0000_8000);
  endtask

  task automatic t_wrap;
    csr_wr(32'hFFFF_FFF1);
    chk("R2 high base", rdata, 32'hFFFF_FFF1);
    take_trap(1'b1, 6'd7);
    chk("R6 wrap pc", pc, 32'h0000_000C);
  endtask

  task automatic t_collide;
    csr_wr(32'h0000_1000);
    @(negedge clk); we = 1'b1; wdata = 32'h0000_3001; req = 1'b1; irq = 1'b1; code = 6'd3;
    @(negedge clk); we = 1'b0; req = 1'b0;
    chk("R9 old value used", pc, 32'h0000_1000);
    chk("R9 write landed", rdata, 32'h0000_3001);
    take_trap(1'b1, 6'd3);
    chk("R9 new value next", pc, 32'h0000_300C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_direct;
    t_vectored;
    t_warl;
    t_wrap;
    t_collide;
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule